// File: doc/BRIEF.md
# Upper-Word Signed Multiply with Optional Rounding

This unit multiplies two signed words and hands back only the upper word of the double-width result. An accumulator word may be brought in as well. It sits at weight 2^W, with a zero lower word, and the product is then added to it or taken away from it. When rounding is requested, the most significant bit of the lower word that is thrown away is added into the returned upper word. That sum wraps at W bits. The unit produces no condition flags of any kind.

Operations enter one at a time with an input strobe and may follow one another on every cycle. Each operation comes out exactly two cycles later. The first stage forms the product, either in one piece or as two registered partial products. The second stage adds the partials, brings in the accumulator, rounds and registers the word. Alongside the operands, the unit takes the four register indices the operation names. It raises a flag next to the result when any index that the chosen mode uses is the reserved all-ones index. The result itself is still produced normally.

There is no controlling state machine. Every input strobe is an independent operation moving down a fixed two-stage pipeline. The only enumerated type is the mode: MODE_MUL (00), MODE_ACC (01), MODE_SUB (10) and MODE_RSVD (11).

Top module: `msw_round_mac`

## Requirements
- R1: out_valid rises exactly two clock cycles after each cycle in which in_valid is high, once per accepted operation. Operations may arrive on consecutive cycles.
- R2: With op_mode 2'b00, result is bits 2W-1:W of the signed product of opa and opb, both taken as two's-complement W-bit values.
- R3: With op_mode 2'b01, the intermediate is acc placed in bits 2W-1:W over a zero lower word, plus the signed product. result is the upper W bits of that intermediate.
- R4: With op_mode 2'b10, the intermediate is the same aligned accumulator value minus the signed product. result is its upper W bits.
- R5: When round_en is 1, bit W-1 of the intermediate is added to the upper word. The sum wraps modulo 2^W.
- R6: op_mode 2'b11 behaves exactly like 2'b00. In particular the accumulator index is not checked in that mode.
- R7: out_unpred is high together with out_valid when idx_d, idx_n or idx_m equals the all-ones index (15 for 4-bit indices). It is also high when idx_a equals it in modes 2'b01 or 2'b10. In mode 2'b00, idx_a has no effect.
- R8: While rst_n is low, and until the first result, out_valid, out_unpred and result are zero.
- R9: result and out_unpred hold their last values in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_mode | input | 2 | 00 multiply, 01 accumulate, 10 subtract from accumulator, 11 as 00 |
| round_en | input | 1 | Add bit W-1 of the intermediate to the returned word |
| opa | input | W | First signed multiplicand |
| opb | input | W | Second signed multiplicand |
| acc | input | W | Accumulator word, aligned to the upper half |
| idx_d | input | IDX_W | Destination register index |
| idx_n | input | IDX_W | First operand register index |
| idx_m | input | IDX_W | Second operand register index |
| idx_a | input | IDX_W | Accumulator register index |
| out_valid | output | 1 | Result strobe |
| result | output | W | Upper word of the intermediate, rounded if asked |
| out_unpred | output | 1 | A used index is the reserved all-ones index |

## Verification
The bench builds the unit with the default parameters: W of 32, 4-bit indices and the split partial-product multiplier. At these values the real word-boundary corners come up directly: the most negative operand squared, a product of exactly -2^31 whose rounding wraps the upper word from all ones to zero, and a positive upper word that rounds over to the most negative one. The split setting also exercises the signed/unsigned partial-product recombination across the half-word boundary. Random operands in all four modes then run back to back against a queue of values computed from 64-bit arithmetic in the bench.

// File: rtl/msw_pkg.sv
package msw_pkg;

    typedef enum logic [1:0] {
        MODE_MUL  = 2'b00,
        MODE_ACC  = 2'b01,
        MODE_SUB  = 2'b10,
        MODE_RSVD = 2'b11
    } msw_mode_e;

endpackage

// File: rtl/msw_index_check.sv
module msw_index_check
    import msw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  msw_mode_e          mode,
    input  logic [IDX_W-1:0]   idx_d,
    input  logic [IDX_W-1:0]   idx_n,
    input  logic [IDX_W-1:0]   idx_m,
    input  logic [IDX_W-1:0]   idx_a,
    output logic               unpred
);
    localparam logic [IDX_W-1:0] RESERVED_IDX = {IDX_W{1'b1}};

    logic core_bad;
    logic acc_used;

    always_comb begin
        core_bad = (idx_d == RESERVED_IDX) || (idx_n == RESERVED_IDX) ||
                   (idx_m == RESERVED_IDX);
        unique case (mode)
            MODE_ACC, MODE_SUB: acc_used = 1'b1;
            default:            acc_used = 1'b0;
        endcase
        unpred = core_bad || (acc_used && (idx_a == RESERVED_IDX));
    end
endmodule

// File: rtl/msw_product_stage.sv
module msw_product_stage
    import msw_pkg::*;
#(
    parameter int W         = 32,
    parameter bit SPLIT_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    output logic [2*W-1:0]    term_hi,
    output logic [2*W-1:0]    term_lo
);
    localparam int PW   = 2 * W;
    localparam int HALF = W / 2;
    localparam int UPW  = W - HALF;

    logic [PW-1:0] next_hi;
    logic [PW-1:0] next_lo;

    generate
        if (SPLIT_MUL) begin : g_split
            logic signed [UPW-1:0]  b_upper;
            logic signed [HALF:0]   b_lower;
            logic signed [PW-1:0]   pp_upper;
            logic signed [PW-1:0]   pp_lower;
            always_comb begin
                b_upper  = $signed(opb[W-1:HALF]);
                b_lower  = $signed({1'b0, opb[HALF-1:0]});
                pp_upper = $signed(opa) * b_upper;
                pp_lower = $signed(opa) * b_lower;
                next_hi  = pp_upper <<< HALF;
                next_lo  = pp_lower;
            end
        end else begin : g_whole
            logic signed [PW-1:0] full_prod;
            always_comb begin
                full_prod = $signed(opa) * $signed(opb);
                next_hi   = full_prod;
                next_lo   = '0;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_hi <= '0;
            term_lo <= '0;
        end else if (in_valid) begin
            term_hi <= next_hi;
            term_lo <= next_lo;
        end
    end
endmodule

// File: rtl/msw_combine_stage.sv
module msw_combine_stage
    import msw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stg_valid,
    input  msw_mode_e         stg_mode,
    input  logic              stg_round,
    input  logic [W-1:0]      stg_acc,
    input  logic [2*W-1:0]    term_hi,
    input  logic [2*W-1:0]    term_lo,
    output logic [W-1:0]      word_out
);
    localparam int PW = 2 * W;

    logic [PW-1:0] product;
    logic [PW-1:0] aligned_acc;
    logic [PW-1:0] inter;
    logic [W-1:0]  upper;
    logic [W-1:0]  rounded;

    always_comb begin
        product     = term_hi + term_lo;
        aligned_acc = {stg_acc, {W{1'b0}}};
        unique case (stg_mode)
            MODE_ACC: inter = aligned_acc + product;
            MODE_SUB: inter = aligned_acc - product;
            default:  inter = product;
        endcase
        upper   = inter[PW-1:W];
        rounded = upper + {{(W-1){1'b0}}, stg_round & inter[W-1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
        end else if (stg_valid) begin
            word_out <= rounded;
        end
    end
endmodule

// File: rtl/msw_round_mac.sv
module msw_round_mac
    import msw_pkg::*;
#(
    parameter int W         = 32,
    parameter int IDX_W     = 4,
    parameter bit SPLIT_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_mode,
    input  logic              round_en,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [W-1:0]      acc,
    input  logic [IDX_W-1:0]  idx_d,
    input  logic [IDX_W-1:0]  idx_n,
    input  logic [IDX_W-1:0]  idx_m,
    input  logic [IDX_W-1:0]  idx_a,
    output logic              out_valid,
    output logic [W-1:0]      result,
    output logic              out_unpred
);
    msw_mode_e     in_mode;
    logic          in_unpred;

    logic          s1_valid;
    msw_mode_e     s1_mode;
    logic          s1_round;
    logic [W-1:0]  s1_acc;
    logic          s1_unpred;
    logic [2*W-1:0] s1_hi;
    logic [2*W-1:0] s1_lo;

    assign in_mode = msw_mode_e'(op_mode);

    msw_index_check #(.IDX_W(IDX_W)) u_idx (
        .mode   (in_mode),
        .idx_d  (idx_d),
        .idx_n  (idx_n),
        .idx_m  (idx_m),
        .idx_a  (idx_a),
        .unpred (in_unpred)
    );

    msw_product_stage #(.W(W), .SPLIT_MUL(SPLIT_MUL)) u_prod (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .opa      (opa),
        .opb      (opb),
        .term_hi  (s1_hi),
        .term_lo  (s1_lo)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_mode   <= MODE_MUL;
            s1_round  <= 1'b0;
            s1_acc    <= '0;
            s1_unpred <= 1'b0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode   <= in_mode;
                s1_round  <= round_en;
                s1_acc    <= acc;
                s1_unpred <= in_unpred;
            end
        end
    end

    msw_combine_stage #(.W(W)) u_comb (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_valid (s1_valid),
        .stg_mode  (s1_mode),
        .stg_round (s1_round),
        .stg_acc   (s1_acc),
        .term_hi   (s1_hi),
        .term_lo   (s1_lo),
        .word_out  (result)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_unpred <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_unpred <= s1_unpred;
            end
        end
    end
endmodule

// File: rtl/msw_round_mac_chk.sv
module msw_round_mac_chk #(
    parameter int W     = 32,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_mode,
    input  logic              round_en,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [W-1:0]      acc,
    input  logic [IDX_W-1:0]  idx_d,
    input  logic [IDX_W-1:0]  idx_n,
    input  logic [IDX_W-1:0]  idx_m,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic              out_valid,
    input  logic [W-1:0]      result,
    input  logic              out_unpred
);
    localparam int PW = 2 * W;
    localparam logic [IDX_W-1:0] ALL_ONES = {IDX_W{1'b1}};

    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    function automatic logic [W-1:0] ref_word(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [W-1:0] c, input logic [1:0] md,
                                              input logic rnd);
        logic signed [PW-1:0] p;
        logic [PW-1:0] t;
        p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        if (md == 2'b01)      t = {c, {W{1'b0}}} + p;
        else if (md == 2'b10) t = {c, {W{1'b0}}} - p;
        else                  t = p;
        return t[PW-1:W] + {{(W-1){1'b0}}, rnd & t[W-1]};
    endfunction

    function automatic logic ref_flag(input logic [1:0] md, input logic [IDX_W-1:0] d,
                                      input logic [IDX_W-1:0] n, input logic [IDX_W-1:0] m,
                                      input logic [IDX_W-1:0] a);
        return (d == ALL_ONES) || (n == ALL_ONES) || (m == ALL_ONES) ||
               ((md == 2'b01 || md == 2'b10) && a == ALL_ONES);
    endfunction

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |-> $past(in_valid, 2));

    a_r2_r5_value: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |->
        result == ref_word($past(opa, 2), $past(opb, 2), $past(acc, 2),
                           $past(op_mode, 2), $past(round_en, 2)));

    a_r7_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |->
        out_unpred == ref_flag($past(op_mode, 2), $past(idx_d, 2), $past(idx_n, 2),
                               $past(idx_m, 2), $past(idx_a, 2)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && !out_valid) |-> ($stable(result) && $stable(out_unpred)));
endmodule

bind msw_round_mac msw_round_mac_chk #(.W(W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_mode    (op_mode),
    .round_en   (round_en),
    .opa        (opa),
    .opb        (opb),
    .acc        (acc),
    .idx_d      (idx_d),
    .idx_n      (idx_n),
    .idx_m      (idx_m),
    .idx_a      (idx_a),
    .out_valid  (out_valid),
    .result     (result),
    .out_unpred (out_unpred)
);

// File: tb/tb_msw_round_mac.sv
module tb_msw_round_mac;
    localparam int W = 32;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] op_mode = 2'b00;
    logic round_en = 1'b0;
    logic [W-1:0] opa = '0, opb = '0, acc = '0;
    logic [IW-1:0] idx_d = '0, idx_n = '0, idx_m = '0, idx_a = '0;
    logic out_valid, out_unpred;
    logic [W-1:0] result;

    always #4 clk = ~clk;

    msw_round_mac #(.W(W), .IDX_W(IW), .SPLIT_MUL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .round_en(round_en), .opa(opa), .opb(opb), .acc(acc),
        .idx_d(idx_d), .idx_n(idx_n), .idx_m(idx_m), .idx_a(idx_a),
        .out_valid(out_valid), .result(result), .out_unpred(out_unpred)
    );

    typedef struct {
        logic [W-1:0] res;
        logic         flag;
        int           cyc;
        string        req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [W-1:0] last_res = '0;
    logic last_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] c, input logic [1:0] md,
                                           input logic rnd);
        logic signed [63:0] p;
        logic [63:0] t;
        p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        case (md)
            2'b01:   t = {c, 32'h0} + p;
            2'b10:   t = {c, 32'h0} - p;
            default: t = p;
        endcase
        return t[63:32] + {31'h0, rnd & t[31]};
    endfunction

    task automatic drive(input logic [1:0] md, input logic rnd, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] c,
                         input logic [IW-1:0] d, input logic [IW-1:0] n,
                         input logic [IW-1:0] m, input logic [IW-1:0] ai,
                         input string req);
        exp_t e;
        in_valid = 1'b1; op_mode = md; round_en = rnd;
        opa = a; opb = b; acc = c;
        idx_d = d; idx_n = n; idx_m = m; idx_a = ai;
        e.res  = model(a, b, c, md, rnd);
        e.flag = (d == 4'hF) || (n == 4'hF) || (m == 4'hF) ||
                 ((md == 2'b01 || md == 2'b10) && ai == 4'hF);
        e.cyc  = cyc;
        e.req  = req;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: compares each result as it appears, and checks hold on idle cycles
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R1 unexpected result", result, '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.cyc + 2, "R1 latency", W'(cyc), W'(e.cyc + 2));
                    check(result == e.res, e.req, result, e.res);
                    check(out_unpred == e.flag, "R7 unpredictable flag",
                          {31'h0, out_unpred}, {31'h0, e.flag});
                end
                last_res  = result;
                last_flag = out_unpred;
            end else begin
                check(result == last_res, "R9 result hold", result, last_res);
                check(out_unpred == last_flag, "R9 flag hold",
                      {31'h0, out_unpred}, {31'h0, last_flag});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", sb.size(), 0);
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R8 reset valid", {31'h0, out_valid}, '0);
        check(result == '0, "R8 reset result", result, '0);
        check(out_unpred == 1'b0, "R8 reset flag", {31'h0, out_unpred}, '0);
        rst_n = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R8 idle after reset", {31'h0, out_valid}, '0);

        // R2 multiply corners
        drive(2'b00, 0, 32'h8000_0000, 32'h8000_0000, 0, 1, 2, 3, 4, "R2 min squared");
        idle(3);
        drive(2'b00, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, 2, 3, 4, "R2 minus one squared");
        drive(2'b00, 0, 32'h7FFF_FFFF, 32'h8000_0000, 0, 1, 2, 3, 4, "R2 max times min");
        drive(2'b00, 0, 32'h1234_5678, 32'h0001_0000, 0, 1, 2, 3, 4, "R2 half shift");
        // R5 rounding, including the wrap of the upper word
        drive(2'b00, 1, 32'h0000_0001, 32'h8000_0000, 0, 1, 2, 3, 4, "R5 wrap to zero");
        drive(2'b00, 1, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, 2, 3, 4, "R5 round up to one");
        drive(2'b00, 0, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, 2, 3, 4, "R5 no round");
        drive(2'b01, 1, 32'h0000_0001, 32'h8000_0000, 32'h8000_0000, 1, 2, 3, 4,
              "R5 round overflows positive");
        // R3 accumulate, R4 subtract
        drive(2'b01, 0, 32'h0001_0000, 32'h0001_0000, 32'h0000_0005, 1, 2, 3, 4, "R3 acc add");
        drive(2'b01, 0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1, 2, 3, 4,
              "R3 acc borrow from upper");
        drive(2'b10, 0, 32'h0001_0000, 32'h0003_0000, 32'h0000_0010, 1, 2, 3, 4, "R4 sub");
        drive(2'b10, 1, 32'h0000_0001, 32'h8000_0000, 32'h0000_0000, 1, 2, 3, 4,
              "R4 sub with round");
        drive(2'b10, 0, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1, 2, 3, 4,
              "R4 sub small product");
        // R6 reserved mode acts as multiply, ignores acc and its index
        drive(2'b11, 0, 32'h0004_0000, 32'h0004_0000, 32'hDEAD_BEEF, 1, 2, 3, 15,
              "R6 reserved as multiply");
        // R7 index checks
        drive(2'b00, 0, 32'h1, 32'h1, 0, 1, 2, 3, 15, "R7 acc index ignored in mul");
        drive(2'b01, 0, 32'h1, 32'h1, 0, 1, 2, 3, 15, "R7 acc index in acc mode");
        drive(2'b10, 0, 32'h1, 32'h1, 0, 1, 2, 3, 15, "R7 acc index in sub mode");
        drive(2'b00, 0, 32'h1, 32'h1, 0, 15, 2, 3, 4, "R7 dest index");
        drive(2'b00, 0, 32'h1, 32'h1, 0, 1, 15, 3, 4, "R7 first operand index");
        drive(2'b00, 0, 32'h1, 32'h1, 0, 1, 2, 15, 4, "R7 second operand index");
        idle(4);

        // random streaming in all modes, with gaps
        for (int i = 0; i < 300; i++) begin
            logic [1:0] md;
            md = 2'($urandom_range(0, 3));
            drive(md, 1'($urandom_range(0, 1)), $urandom(), $urandom(), $urandom(),
                  4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                  md == 2'b01 ? "R3 random" : md == 2'b10 ? "R4 random" :
                  md == 2'b11 ? "R6 random" : "R2 random");
            if ((i % 7) == 0) idle(1 + (i % 3));
        end
        idle(4);
        check(sb.size() == 0, "R1 all results returned", W'(sb.size()), '0);
        finish_run();
    end
endmodule